// File: doc/BRIEF.md
# SPI FIFO and Interrupt Controller

This block sits between a register-side host interface and an SPI shift engine. It holds a four-byte transmit queue, which the host fills and the engine drains, and a four-byte receive queue, which the engine fills and the host drains. It raises level-sensitive transmit and receive interrupts at a byte-count threshold that a 2-bit level setting selects. It also applies level-held purge controls and a policy for bytes that arrive when the receive queue is full.

A configuration bit selects how a transfer starts. In write-start mode, every byte the transmit queue accepts causes a one-cycle start request to the engine, and only the transmit interrupt is active. In read-start mode, every host read of the receive queue causes the start request, and only the receive interrupt is active. The shift engine is not part of this block. It appears as a byte-pull port (valid/ready) and a byte-push port (valid strobe).

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: Each queue holds at most 4 bytes. A host write to a full transmit queue is dropped, and `tx_count` stays at 4. Both counts are 0 after reset.
- R2: `eng_tx_valid` is high exactly when the transmit queue holds a byte and purge is off. `eng_tx_data` presents the bytes in host-write order, and one byte is consumed on each cycle where both `eng_tx_valid` and `eng_tx_ready` are high.
- R3: With `cfg_start_on_wr`=1, `tx_irq` is high when the free transmit slots (4 minus `tx_count`) are at least the threshold. The threshold is 1, 2, 3 or 4 for `cfg_irq_lvl` = 00, 01, 10 or 11. With `cfg_start_on_wr`=0, `tx_irq` is low.
- R4: With `cfg_start_on_wr`=0 and receive purge off, `rx_irq` is high when `rx_count` is at least the same threshold or the receive queue is full. With `cfg_start_on_wr`=1, `rx_irq` is low.
- R5: While `cfg_tx_purge` is high, the transmit queue empties on the next edge, `eng_tx_valid` is low, and host writes are ignored without a start request. The queue stays empty after purge is released.
- R6: While `cfg_rx_purge` is high, the receive queue empties on the next edge, bytes from the engine are discarded, and `rx_irq` is low.
- R7: With `cfg_start_on_wr`=1, every host write that the transmit queue accepts produces `eng_start`=1 for exactly the following cycle. A write that is not accepted produces no start.
- R8: With `cfg_start_on_wr`=0, every `host_rd_en` cycle produces `eng_start`=1 on the following cycle. This includes reads while receive purge is set and reads of an empty queue.
- R9: With `cfg_rx_replace`=0, a byte that arrives while the receive queue is full is dropped, and the stored bytes are unchanged.
- R10: With `cfg_rx_replace`=1, a byte that arrives while the receive queue is full replaces the newest stored byte. The older bytes are unchanged.
- R11: Either kind of receive overflow sets `rx_ovf` on the next edge. It stays set until a cycle with `host_stat_rd`=1 clears it, and a new overflow in that same cycle wins over the clear.
- R12: `host_rd_data` shows the oldest receive byte, and a `host_rd_en` cycle removes it. Reading an empty queue returns 0 and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_irq_lvl | input | 2 | Interrupt threshold select (threshold = value + 1) |
| cfg_tx_purge | input | 1 | Level-held transmit purge |
| cfg_rx_purge | input | 1 | Level-held receive purge |
| cfg_start_on_wr | input | 1 | 1: write starts a transfer; 0: read starts a transfer |
| cfg_rx_replace | input | 1 | 1: overflow replaces newest byte; 0: overflow drops byte |
| host_wr_en | input | 1 | Host write strobe into transmit queue |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe from receive queue |
| host_rd_data | output | 8 | Oldest receive byte (0 when empty) |
| host_stat_rd | input | 1 | Status read; clears the overflow flag |
| eng_start | output | 1 | One-cycle transfer start request to the engine |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_data | output | 8 | Transmit byte to the engine |
| eng_tx_ready | input | 1 | Engine consumes the presented byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte from the engine |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_count | output | 3 | Transmit queue fill level |
| rx_count | output | 3 | Receive queue fill level |

## Verification
The assertions check several properties on every cycle. Fill levels never exceed the depth, and a full queue with no pop does not grow. A purge empties its queue on the next edge and holds the engine-side valid low. The two interrupts are never high together, and a full receive queue in read-start mode always interrupts. Start requests follow the selected trigger, and the overflow flag sets on an overflow and holds until a status read. Only the bench scenarios can show byte ordering through each queue, the exact interrupt threshold for each level setting, and which byte survives a drop or a replace overflow, because these depend on the data values and the order of the stimulus.

// File: rtl/spi_fq_pkg.sv
package spi_fq_pkg;

    localparam int FQ_DATA_W = 8;
    localparam int FQ_DEPTH  = 4;
    localparam int FQ_LVL_W  = 2;

    typedef enum logic [FQ_LVL_W-1:0] {
        LVL_ONE   = 2'b00,
        LVL_TWO   = 2'b01,
        LVL_THREE = 2'b10,
        LVL_FOUR  = 2'b11
    } fq_lvl_e;

    typedef struct packed {
        fq_lvl_e lvl;
        logic    tx_purge;
        logic    rx_purge;
        logic    start_on_wr;
        logic    rx_replace;
    } fq_cfg_t;

    // Byte-count threshold selected by a level code.
    function automatic int unsigned fq_thresh(input fq_lvl_e lvl);
        return int'(lvl) + 1;
    endfunction

endpackage

// File: rtl/spi_fq_ring.sv
module spi_fq_ring #(
    parameter  int DATA_W = spi_fq_pkg::FQ_DATA_W,
    parameter  int DEPTH  = spi_fq_pkg::FQ_DEPTH,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              purge,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              replace_last,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              push_ok,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr, last_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              is_full, is_empty, do_pop, do_push, do_ovf;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_full  = (cnt == CNT_W'(DEPTH));
    assign is_empty = (cnt == '0);
    assign do_pop   = pop && !is_empty && !purge;
    assign do_push  = push && !purge && (!is_full || do_pop);
    assign do_ovf   = push && !purge && is_full && !do_pop;
    assign last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || purge) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (do_push)
                mem[wr_ptr] <= push_data;
            else if (do_ovf && replace_last)
                mem[last_ptr] <= push_data;
        end
    end

    assign head     = mem[rd_ptr];
    assign count    = cnt;
    assign empty    = is_empty;
    assign push_ok  = do_push;
    assign overflow = do_ovf;

    AST_RING_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R1

    AST_RING_NO_GROW_FULL: assert property (@(posedge clk) disable iff (rst)
        is_full && !pop && !purge |=> cnt == CNT_W'(DEPTH)); // R1

    AST_RING_PURGE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        purge |=> cnt == '0); // R5

endmodule

// File: rtl/spi_fq_irq.sv
module spi_fq_irq #(
    parameter  int DEPTH = spi_fq_pkg::FQ_DEPTH,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  spi_fq_pkg::fq_cfg_t  cfg,
    input  logic [CNT_W-1:0]     tx_cnt,
    input  logic [CNT_W-1:0]     rx_cnt,
    output logic                 tx_irq,
    output logic                 rx_irq
);

    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] tx_free;
    logic             rx_full;

    assign thr     = CNT_W'(spi_fq_pkg::fq_thresh(cfg.lvl));
    assign tx_free = CNT_W'(DEPTH) - tx_cnt;
    assign rx_full = (rx_cnt == CNT_W'(DEPTH));

    always_comb begin
        tx_irq = cfg.start_on_wr && (tx_free >= thr);
        rx_irq = !cfg.start_on_wr && !cfg.rx_purge && ((rx_cnt >= thr) || rx_full);
    end

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(tx_irq && rx_irq)); // R3

    AST_RX_IRQ_PURGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg.rx_purge |-> !rx_irq); // R6

    AST_RX_IRQ_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        !cfg.start_on_wr && !cfg.rx_purge && rx_cnt == CNT_W'(DEPTH) |-> rx_irq); // R4

endmodule

// File: rtl/spi_fq_start.sv
module spi_fq_start (
    input  logic clk,
    input  logic rst,
    input  logic start_on_wr,
    input  logic wr_accepted,
    input  logic rd_req,
    output logic start
);

    always_ff @(posedge clk) begin
        if (rst) start <= 1'b0;
        else     start <= start_on_wr ? wr_accepted : rd_req;
    end

    AST_START_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        start_on_wr && wr_accepted |=> start); // R7

    AST_START_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !start_on_wr && rd_req |=> start); // R8

    AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(wr_accepted || rd_req)); // R7

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl #(
    parameter  int DATA_W = spi_fq_pkg::FQ_DATA_W,
    parameter  int DEPTH  = spi_fq_pkg::FQ_DEPTH,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_irq_lvl,
    input  logic              cfg_tx_purge,
    input  logic              cfg_rx_purge,
    input  logic              cfg_start_on_wr,
    input  logic              cfg_rx_replace,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              host_stat_rd,
    output logic              eng_start,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_ready,
    input  logic              eng_rx_valid,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic              rx_ovf,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count
);

    import spi_fq_pkg::*;

    fq_cfg_t           cfg;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic              tx_empty, rx_empty;
    logic              tx_push_ok, rx_push_ok;
    logic              tx_drop, rx_over;
    logic              tx_pop;
    logic              ovf_q;

    assign cfg.lvl         = fq_lvl_e'(cfg_irq_lvl);
    assign cfg.tx_purge    = cfg_tx_purge;
    assign cfg.rx_purge    = cfg_rx_purge;
    assign cfg.start_on_wr = cfg_start_on_wr;
    assign cfg.rx_replace  = cfg_rx_replace;

    assign eng_tx_valid = !tx_empty && !cfg.tx_purge;
    assign tx_pop       = eng_tx_valid && eng_tx_ready;

    spi_fq_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_ring_i (
        .clk          (clk),
        .rst          (rst),
        .purge        (cfg.tx_purge),
        .push         (host_wr_en),
        .push_data    (host_wr_data),
        .replace_last (1'b0),
        .pop          (tx_pop),
        .head         (tx_head),
        .count        (tx_count),
        .empty        (tx_empty),
        .push_ok      (tx_push_ok),
        .overflow     (tx_drop)
    );

    spi_fq_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_ring_i (
        .clk          (clk),
        .rst          (rst),
        .purge        (cfg.rx_purge),
        .push         (eng_rx_valid),
        .push_data    (eng_rx_data),
        .replace_last (cfg.rx_replace),
        .pop          (host_rd_en),
        .head         (rx_head),
        .count        (rx_count),
        .empty        (rx_empty),
        .push_ok      (rx_push_ok),
        .overflow     (rx_over)
    );

    assign eng_tx_data  = tx_head;
    assign host_rd_data = rx_empty ? '0 : rx_head;

    spi_fq_irq #(.DEPTH(DEPTH)) irq_i (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .tx_cnt (tx_count),
        .rx_cnt (rx_count),
        .tx_irq (tx_irq),
        .rx_irq (rx_irq)
    );

    spi_fq_start start_i (
        .clk         (clk),
        .rst         (rst),
        .start_on_wr (cfg.start_on_wr),
        .wr_accepted (tx_push_ok),
        .rd_req      (host_rd_en),
        .start       (eng_start)
    );

    always_ff @(posedge clk) begin
        if (rst)               ovf_q <= 1'b0;
        else if (rx_over)      ovf_q <= 1'b1;
        else if (host_stat_rd) ovf_q <= 1'b0;
    end
    assign rx_ovf = ovf_q;

    AST_TX_PURGE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        cfg_tx_purge |-> !eng_tx_valid); // R5

    AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        tx_drop && !cfg_tx_purge |=> tx_count == CNT_W'(DEPTH)); // R1

    AST_RX_PURGE_DISCARD: assert property (@(posedge clk) disable iff (rst)
        cfg_rx_purge |=> rx_count == '0); // R6

    AST_RX_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        rx_push_ok && !host_rd_en |=> rx_count != '0); // R12

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (rst)
        rx_over |=> rx_ovf); // R11

    AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        rx_ovf && !host_stat_rd |=> rx_ovf); // R11

endmodule

// File: tb/spi_fifo_irq_ctrl_tb.sv
`timescale 1ns/1ps
module spi_fifo_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_irq_lvl;
    logic       cfg_tx_purge, cfg_rx_purge, cfg_start_on_wr, cfg_rx_replace;
    logic       host_wr_en, host_rd_en, host_stat_rd;
    logic [7:0] host_wr_data, host_rd_data;
    logic       eng_start, eng_tx_valid, eng_tx_ready, eng_rx_valid;
    logic [7:0] eng_tx_data, eng_rx_data;
    logic       tx_irq, rx_irq, rx_ovf;
    logic [2:0] tx_count, rx_count;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_fifo_irq_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cfg_irq_lvl(cfg_irq_lvl), .cfg_tx_purge(cfg_tx_purge),
        .cfg_rx_purge(cfg_rx_purge), .cfg_start_on_wr(cfg_start_on_wr),
        .cfg_rx_replace(cfg_rx_replace),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .host_stat_rd(host_stat_rd),
        .eng_start(eng_start), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_ovf(rx_ovf),
        .tx_count(tx_count), .rx_count(rx_count)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        eng_rx_valid = 1'b1; eng_rx_data = b;
        tick();
        eng_rx_valid = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] d);
        d = host_rd_data;
        host_rd_en = 1'b1;
        tick();
        host_rd_en = 1'b0;
    endtask

    task automatic eng_pull(output logic [7:0] d);
        d = eng_tx_data;
        eng_tx_ready = 1'b1;
        tick();
        eng_tx_ready = 1'b0;
    endtask

    task automatic sweep_tx_irq(input int cnt);
        for (int l = 0; l < 4; l++) begin
            cfg_irq_lvl = 2'(l);
            #0.1;
            chk("R3", $sformatf("tx_irq lvl=%0d cnt=%0d", l, cnt), int'(tx_irq),
                int'((4 - cnt) >= l + 1));
        end
        cfg_irq_lvl = 2'd0;
    endtask

    task automatic sweep_rx_irq(input int cnt);
        for (int l = 0; l < 4; l++) begin
            cfg_irq_lvl = 2'(l);
            #0.1;
            chk("R4", $sformatf("rx_irq lvl=%0d cnt=%0d", l, cnt), int'(rx_irq),
                int'(cnt >= l + 1 || cnt == 4));
        end
        cfg_irq_lvl = 2'd0;
    endtask

    task automatic t_reset();
        chk("R1", "tx_count after reset", int'(tx_count), 0);
        chk("R1", "rx_count after reset", int'(rx_count), 0);
        chk("R2", "eng_tx_valid after reset", int'(eng_tx_valid), 0);
        chk("R11", "rx_ovf after reset", int'(rx_ovf), 0);
        chk("R7", "eng_start after reset", int'(eng_start), 0);
    endtask

    task automatic t_tx_path();
        logic [7:0] d;
        cfg_start_on_wr = 1'b1;
        sweep_tx_irq(0);
        for (int i = 0; i < 4; i++) begin
            host_write(8'hA0 + 8'(i));
            chk("R7", "start after accepted write", int'(eng_start), 1);
            chk("R1", "tx_count grows", int'(tx_count), i + 1);
            sweep_tx_irq(i + 1);
        end
        host_write(8'hFF);
        chk("R1", "tx_count capped at 4", int'(tx_count), 4);
        chk("R7", "no start on dropped write", int'(eng_start), 0);
        cfg_start_on_wr = 1'b0;
        #0.1;
        chk("R3", "tx_irq off in read-start mode", int'(tx_irq), 0);
        cfg_start_on_wr = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R2", "valid while non-empty", int'(eng_tx_valid), 1);
            eng_pull(d);
            chk("R2", "tx byte order", int'(d), 8'hA0 + i);
        end
        chk("R2", "valid low when empty", int'(eng_tx_valid), 0);
    endtask

    task automatic t_tx_purge();
        logic [7:0] d;
        cfg_start_on_wr = 1'b1;
        host_write(8'h11);
        host_write(8'h22);
        cfg_tx_purge = 1'b1;
        #0.1;
        chk("R5", "valid low under purge", int'(eng_tx_valid), 0);
        tick();
        chk("R5", "tx emptied by purge", int'(tx_count), 0);
        host_write(8'h33);
        chk("R5", "write ignored under purge", int'(tx_count), 0);
        chk("R5", "no start under purge", int'(eng_start), 0);
        cfg_tx_purge = 1'b0;
        tick();
        chk("R5", "still empty after release", int'(tx_count), 0);
        chk("R5", "valid low after release", int'(eng_tx_valid), 0);
        host_write(8'h5A);
        eng_pull(d);
        chk("R2", "byte after purge", int'(d), 8'h5A);
    endtask

    task automatic t_rx_path();
        logic [7:0] d;
        cfg_start_on_wr = 1'b0;
        sweep_rx_irq(0);
        for (int i = 0; i < 4; i++) begin
            eng_push(8'hC0 + 8'(i));
            chk("R12", "rx_count grows", int'(rx_count), i + 1);
            sweep_rx_irq(i + 1);
        end
        cfg_start_on_wr = 1'b1;
        #0.1;
        chk("R4", "rx_irq off in write-start mode", int'(rx_irq), 0);
        cfg_start_on_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            host_read(d);
            chk("R12", "rx byte order", int'(d), 8'hC0 + i);
            chk("R8", "start after read", int'(eng_start), 1);
        end
        host_read(d);
        chk("R12", "empty read returns 0", int'(d), 0);
        chk("R12", "empty read keeps count", int'(rx_count), 0);
        chk("R8", "start on empty read", int'(eng_start), 1);
        tick();
        chk("R8", "start is one cycle", int'(eng_start), 0);
    endtask

    task automatic t_rx_purge();
        logic [7:0] d;
        cfg_start_on_wr = 1'b0;
        eng_push(8'h01);
        eng_push(8'h02);
        cfg_rx_purge = 1'b1;
        #0.1;
        chk("R6", "rx_irq low under purge", int'(rx_irq), 0);
        tick();
        chk("R6", "rx emptied by purge", int'(rx_count), 0);
        eng_push(8'h03);
        chk("R6", "incoming byte discarded", int'(rx_count), 0);
        host_read(d);
        chk("R8", "read under purge starts transfer", int'(eng_start), 1);
        cfg_rx_purge = 1'b0;
        tick();
        chk("R6", "empty after release", int'(rx_count), 0);
    endtask

    task automatic t_overflow(input logic replace);
        logic [7:0] d;
        logic [7:0] base;
        base = replace ? 8'h20 : 8'h10;
        cfg_rx_replace = replace;
        for (int i = 0; i < 4; i++) eng_push(base + 8'(i));
        chk("R11", "no overflow yet", int'(rx_ovf), 0);
        eng_push(8'h77);
        chk("R11", "overflow flag set", int'(rx_ovf), 1);
        chk(replace ? "R10" : "R9", "count stays full", int'(rx_count), 4);
        tick();
        chk("R11", "overflow flag holds", int'(rx_ovf), 1);
        for (int i = 0; i < 4; i++) begin
            host_read(d);
            if (replace)
                chk("R10", "replace keeps older, swaps newest", int'(d),
                    (i == 3) ? 8'h77 : base + i);
            else
                chk("R9", "drop keeps stored bytes", int'(d), base + i);
        end
        host_stat_rd = 1'b1;
        tick();
        host_stat_rd = 1'b0;
        chk("R11", "status read clears flag", int'(rx_ovf), 0);
        cfg_rx_replace = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        cfg_irq_lvl = 2'd0; cfg_tx_purge = 1'b0; cfg_rx_purge = 1'b0;
        cfg_start_on_wr = 1'b1; cfg_rx_replace = 1'b0;
        host_wr_en = 1'b0; host_wr_data = '0; host_rd_en = 1'b0; host_stat_rd = 1'b0;
        eng_tx_ready = 1'b0; eng_rx_valid = 1'b0; eng_rx_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick();
        t_reset();
        t_tx_path();
        t_tx_purge();
        t_rx_path();
        t_rx_purge();
        t_overflow(1'b0);
        t_overflow(1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule